// File: doc/BRIEF.md
# Packed Single-to-Double Float Widener

This block widens two IEEE-754 single-precision numbers into two double-precision numbers in one registered step. A 128-bit source word arrives with an input strobe; only its low 64 bits hold operands, one single per 32-bit half. One clock later a 128-bit result appears with a result strobe. Each 32-bit half produces the matching 64-bit half of the result.

Every single-precision value has an exact double-precision equivalent, so the block never rounds. Subnormal inputs become normal doubles. Signalling NaNs are made quiet. Two conditions are detected: an invalid operand, meaning a signalling NaN, and a denormal operand, meaning a subnormal single. Each condition is ORed across both lanes. A separate mask input for each condition decides what happens when it is detected. If the condition is masked, the result is written normally. If it is unmasked, the block raises an exception request and withholds the destination write enable.

Top module: `fpw_widener`

## Requirements
- R1: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high. After reset, `out_valid`, `wr_en`, `exc_req`, both flags and `result` are all zero.
- R2: Source bits 31:0 produce result bits 63:0, and source bits 63:32 produce result bits 127:64. Source bits 127:64 have no effect on any output.
- R3: For a normal single with sign s, exponent e (1..254) and fraction f, the lane output is {s, e+896, f, 29 zero bits}. That is, the sign is at bit 63, the exponent at 62:52 and the fraction at 51:29. No flag is raised.
- R4: A zero or an infinity keeps its sign. It maps to the double zero {s, 63'b0} or the double infinity {s, 11'h7FF, 52'b0}, with no flag.
- R5: A nonzero subnormal single (exponent 0) is normalised exactly. Its leading one is shifted out, the remaining fraction bits are left-justified at bit 51, and the exponent is 896 minus the number of leading zeros in its 23-bit fraction. It sets `flag_denorm`.
- R6: A signalling NaN (exponent 255, fraction bit 22 clear, fraction nonzero) keeps its sign and its fraction bits 21:0 at result lane bits 50:29. Lane bit 51 (the quiet bit) is forced to 1, and the NaN sets `flag_invalid`.
- R7: A quiet NaN (exponent 255, fraction bit 22 set) is widened like R6 and raises no flag.
- R8: `flag_invalid` and `flag_denorm` are each the OR of the two lanes' conditions. Both are low whenever `out_valid` is low.
- R9: `exc_req` is high when `flag_invalid` is high with `mask_invalid` low, or when `flag_denorm` is high with `mask_denorm` low. A mask input of 1 suppresses its condition.
- R10: `wr_en` equals `out_valid` with no exception request. The converted `result` is presented even when `wr_en` is withheld.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source word valid this cycle |
| src | input | 128 | Source word; low 64 bits hold two singles |
| mask_invalid | input | 1 | 1 masks the invalid-operand condition |
| mask_denorm | input | 1 | 1 masks the denormal-operand condition |
| out_valid | output | 1 | Result valid strobe |
| result | output | 128 | Two packed doubles |
| wr_en | output | 1 | Destination write enable |
| flag_invalid | output | 1 | A lane held a signalling NaN |
| flag_denorm | output | 1 | A lane held a subnormal |
| exc_req | output | 1 | Unmasked condition detected |

## Verification
The assertions assume that `src` and both masks are driven to known values whenever `in_valid` is high. They also assume that the mask inputs are sampled in the same cycle as `src`, because the exception request is derived from that cycle's masks. The bench changes inputs only on the falling edge and holds them across the rising edge. It builds operands one class at a time (normal, subnormal, zero, infinity, signalling NaN, quiet NaN), so every lane value falls into a defined encoding with known flag effects. It draws the masks at random and fills the unused upper source half with random data.

// File: rtl/fpw_pkg.sv
package fpw_pkg;
  localparam int SP_W      = 32;
  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;
  localparam int DP_W      = 64;
  localparam int DP_EXP_W  = 11;
  localparam int DP_FRAC_W = 52;
  localparam int PAD_W     = DP_FRAC_W - SP_FRAC_W;
  localparam int REBIAS    = 896;
  localparam int LZ_W      = $clog2(SP_FRAC_W + 1);

  typedef struct packed {
    logic [DP_W-1:0] val;
    logic            snan;
    logic            sub;
  } lane_res_t;

  // Leading zero count of a single-precision fraction; all-zero gives SP_FRAC_W.
  function automatic logic [LZ_W-1:0] fpw_lzc(input logic [SP_FRAC_W-1:0] f);
    logic [LZ_W-1:0] n;
    n = LZ_W'(SP_FRAC_W);
    for (int i = 0; i < SP_FRAC_W; i++)
      if (f[i]) n = LZ_W'(SP_FRAC_W - 1 - i);
    return n;
  endfunction

  // Exact single-to-double widening with condition detection.
  function automatic lane_res_t fpw_widen(input logic [SP_W-1:0] x);
    lane_res_t              r;
    logic                   s;
    logic [SP_EXP_W-1:0]    e;
    logic [SP_FRAC_W-1:0]   f;
    logic [LZ_W-1:0]        lz;
    logic [SP_FRAC_W-1:0]   nf;
    logic [DP_EXP_W-1:0]    de;
    s = x[SP_W-1];
    e = x[SP_W-2 -: SP_EXP_W];
    f = x[SP_FRAC_W-1:0];
    lz = fpw_lzc(f);
    nf = f << ({1'b0, lz} + (LZ_W+1)'(1));
    de = DP_EXP_W'(REBIAS) - DP_EXP_W'(lz);
    r.snan = 1'b0;
    r.sub  = 1'b0;
    if (e == '1) begin
      r.val  = {s, {DP_EXP_W{1'b1}}, (f[SP_FRAC_W-1] | (f != '0)), f[SP_FRAC_W-2:0], {PAD_W{1'b0}}};
      r.snan = (f != '0) && !f[SP_FRAC_W-1];
    end else if (e == '0) begin
      if (f == '0) begin
        r.val = {s, {(DP_W-1){1'b0}}};
      end else begin
        r.val = {s, de, nf, {PAD_W{1'b0}}};
        r.sub = 1'b1;
      end
    end else begin
      r.val = {s, DP_EXP_W'(e) + DP_EXP_W'(REBIAS), f, {PAD_W{1'b0}}};
    end
    return r;
  endfunction
endpackage

// File: rtl/fpw_lane.sv
module fpw_lane
  import fpw_pkg::*;
(
  input  logic [SP_W-1:0] op,
  output logic [DP_W-1:0] wide,
  output logic            is_snan,
  output logic            is_sub
);
  lane_res_t r;
  always_comb begin
    r       = fpw_widen(op);
    wide    = r.val;
    is_snan = r.snan;
    is_sub  = r.sub;
  end
endmodule

// File: rtl/fpw_excp.sv
module fpw_excp #(
  parameter int LANES = 2
) (
  input  logic [LANES-1:0] lane_snan,
  input  logic [LANES-1:0] lane_sub,
  input  logic             mask_invalid,
  input  logic             mask_denorm,
  output logic             any_invalid,
  output logic             any_denorm,
  output logic             raise
);
  always_comb begin
    any_invalid = |lane_snan;
    any_denorm  = |lane_sub;
    raise       = (any_invalid && !mask_invalid) || (any_denorm && !mask_denorm);
  end
endmodule

// File: rtl/fpw_widener.sv
module fpw_widener
  import fpw_pkg::*;
#(
  parameter int LANES = 2,
  parameter int SRC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [SRC_W-1:0] src,
  input  logic             mask_invalid,
  input  logic             mask_denorm,
  output logic             out_valid,
  output logic [SRC_W-1:0] result,
  output logic             wr_en,
  output logic             flag_invalid,
  output logic             flag_denorm,
  output logic             exc_req
);
  localparam int RES_W = LANES * DP_W;

  logic [LANES-1:0]      lane_snan;
  logic [LANES-1:0]      lane_sub;
  logic [DP_W-1:0]       lane_out [LANES];
  logic [RES_W-1:0]      res_d;
  logic                  any_inv, any_den, raise_d;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fpw_lane u_lane (
      .op      (src[g*SP_W +: SP_W]),
      .wide    (lane_out[g]),
      .is_snan (lane_snan[g]),
      .is_sub  (lane_sub[g])
    );
    assign res_d[g*DP_W +: DP_W] = lane_out[g];

    // R6: a flagged signalling NaN leaves the lane as a quiet NaN
    a_r6_snan_made_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      lane_snan[g] |-> (&lane_out[g][DP_W-2:DP_FRAC_W-1]));
    // R5: a renormalised subnormal lands in the exact normal exponent window
    a_r5_sub_exp_window: assert property (@(posedge clk) disable iff (!rst_n)
      lane_sub[g] |-> (lane_out[g][DP_W-2:DP_FRAC_W] != '0 &&
                       lane_out[g][DP_W-2:DP_FRAC_W] <= DP_EXP_W'(REBIAS)));
  end

  fpw_excp #(.LANES(LANES)) u_excp (
    .lane_snan    (lane_snan),
    .lane_sub     (lane_sub),
    .mask_invalid (mask_invalid),
    .mask_denorm  (mask_denorm),
    .any_invalid  (any_inv),
    .any_denorm   (any_den),
    .raise        (raise_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      result       <= '0;
      wr_en        <= 1'b0;
      flag_invalid <= 1'b0;
      flag_denorm  <= 1'b0;
      exc_req      <= 1'b0;
    end else begin
      out_valid    <= in_valid;
      flag_invalid <= in_valid && any_inv;
      flag_denorm  <= in_valid && any_den;
      exc_req      <= in_valid && raise_d;
      wr_en        <= in_valid && !raise_d;
      if (in_valid) result <= SRC_W'(res_d);
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r8_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(flag_invalid || flag_denorm || exc_req || wr_en));
  a_r9_unmasked_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane_snan != '0 && !mask_invalid) |=> exc_req);
  a_r10_clean_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !exc_req) |-> wr_en);
  a_r10_no_write_on_exc: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> !wr_en);
endmodule

// File: tb/fpw_widener_bench.sv
module fpw_widener_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] src = '0;
  logic         mask_invalid = 1'b1;
  logic         mask_denorm = 1'b1;
  logic         out_valid, wr_en, flag_invalid, flag_denorm, exc_req;
  logic [127:0] result;
  int           checks = 0;
  int           errors = 0;

  always #2.5 clk = ~clk;

  fpw_widener u_fpw_widener (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src),
    .mask_invalid(mask_invalid), .mask_denorm(mask_denorm),
    .out_valid(out_valid), .result(result), .wr_en(wr_en),
    .flag_invalid(flag_invalid), .flag_denorm(flag_denorm), .exc_req(exc_req)
  );

  // Reference: decode by class, normalise by repeated doubling.
  function automatic logic [63:0] ref_lane(input logic [31:0] x, output bit inv, output bit den);
    logic [23:0] m;
    int          ex;
    inv = 0; den = 0;
    if (x[30:23] == 8'hFF) begin
      if (x[22:0] == 0) return {x[31], 11'h7FF, 52'h0};
      inv = !x[22];
      return {x[31], 11'h7FF, 1'b1, x[21:0], 29'h0};
    end
    if (x[30:23] == 0) begin
      if (x[22:0] == 0) return {x[31], 63'h0};
      den = 1;
      m = {1'b0, x[22:0]};
      ex = 897;
      while (!m[23]) begin m = m << 1; ex = ex - 1; end
      return {x[31], 11'(ex), m[22:0], 29'h0};
    end
    return {x[31], 11'(int'(x[30:23]) - 127 + 1023), x[22:0], 29'h0};
  endfunction

  task automatic expect_v(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(string tag, logic [127:0] s, bit mi, bit md);
    bit i0, d0, i1, d1, ei, ed, ex;
    logic [127:0] exp;
    exp[63:0]   = ref_lane(s[31:0], i0, d0);
    exp[127:64] = ref_lane(s[63:32], i1, d1);
    ei = i0 | i1; ed = d0 | d1;
    ex = (ei && !mi) || (ed && !md);
    @(negedge clk);
    src = s; mask_invalid = mi; mask_denorm = md; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    src = {$urandom, $urandom, $urandom, $urandom};
    expect_v({tag, " R1 out_valid"}, 128'(out_valid), 128'(1));
    expect_v({tag, " R2 result"}, result, exp);
    expect_v({tag, " R8 flags"}, {126'h0, flag_invalid, flag_denorm}, {126'h0, ei, ed});
    expect_v({tag, " R9 exc_req"}, 128'(exc_req), 128'(ex));
    expect_v({tag, " R10 wr_en"}, 128'(wr_en), 128'(!ex));
  endtask

  function automatic logic [31:0] gen_single(int k);
    logic [31:0] r = $urandom;
    case (k)
      0: begin if (r[30:23] == 0 || r[30:23] == 8'hFF) r[30:23] = 8'h80; end
      1: begin r[30:23] = 0; if (r[22:0] == 0) r[0] = 1'b1; end
      2: r[30:0] = 0;
      3: begin r[30:23] = 8'hFF; r[22:0] = 0; end
      4: begin r[30:23] = 8'hFF; r[22] = 1'b0; if (r[21:0] == 0) r[3] = 1'b1; end
      default: begin r[30:23] = 8'hFF; r[22] = 1'b1; end
    endcase
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [127:0] keep;
    void'($urandom(32'd7734));
    repeat (3) @(negedge clk);
    // R1 reset state
    expect_v("R1 reset outputs", {result, out_valid, wr_en, flag_invalid, flag_denorm, exc_req}, '0);
    rst_n = 1'b1;
    // R3 normal values
    run_op("R3 one/neg2.5", {64'h0, 32'hC020_0000, 32'h3F80_0000}, 1, 1);
    expect_v("R3 1.0 encoding", result[63:0], 128'h3FF0_0000_0000_0000);
    expect_v("R3 -2.5 encoding", result[127:64], 128'hC004_0000_0000_0000);
    // R4 zeros and infinities
    run_op("R4 zeros", {64'h0, 32'h8000_0000, 32'h0000_0000}, 0, 0);
    run_op("R4 infs", {64'h0, 32'hFF80_0000, 32'h7F80_0000}, 0, 0);
    // R5 smallest and largest subnormal, masked and unmasked
    run_op("R5 sub masked", {64'h0, 32'h007F_FFFF, 32'h0000_0001}, 1, 1);
    expect_v("R5 min subnormal", result[63:0], 128'h36A0_0000_0000_0000);
    run_op("R5 sub unmasked", {64'h0, 32'h3F80_0000, 32'h8040_0000}, 1, 0);
    // R6 signalling NaN
    run_op("R6 snan masked", {64'h0, 32'h3F80_0000, 32'h7F80_0001}, 1, 0);
    expect_v("R6 quieted payload", result[63:0], 128'h7FF8_0000_2000_0000);
    run_op("R6 snan unmasked", {64'h0, 32'hFF80_0010, 32'h0}, 0, 1);
    // R7 quiet NaN
    run_op("R7 qnan", {64'h0, 32'hFFC0_0000, 32'h7FC0_1234}, 0, 0);
    // R8 both conditions from different lanes
    run_op("R8 mixed lanes", {64'h0, 32'h7F80_0002, 32'h0000_0100}, 1, 1);
    // R2 upper half ignored
    run_op("R2 upper A", {64'hDEAD_BEEF_0123_4567, 32'h4049_0FDB, 32'h0000_0040}, 1, 1);
    keep = result;
    run_op("R2 upper B", {64'h89AB_CDEF_FFFF_0000, 32'h4049_0FDB, 32'h0000_0040}, 1, 1);
    expect_v("R2 upper bits ignored", result, keep);
    // R1 idle cycle drops out_valid
    @(negedge clk);
    expect_v("R1 idle out_valid", {out_valid, wr_en, exc_req}, '0);
    // Random mix
    for (int n = 0; n < 300; n++) begin
      logic [31:0] a = gen_single($urandom % 6);
      logic [31:0] b = gen_single($urandom % 6);
      run_op("R3 random", {$urandom, $urandom, b, a}, 1'($urandom), 1'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule